// File: doc/BRIEF.md
# Page-Buffered Serial Memory Write Target

This block is the target side of a two-wire serial memory, limited to the write path. On the open-drain bus it recognises a one-byte selector made of a fixed four-bit family code, three bits that must equal the board strap pins, and a direction bit. After the selector it takes a two-byte location, then one data byte or a run of data bytes. The data bytes collect in a 64-byte page buffer. The buffered bytes are copied into the storage array only when the master ends the transfer with a Stop.

That Stop also starts a self-timed programming interval, whose length is a parameter counted in system clock cycles. For the whole interval the block leaves SDA high in every acknowledge slot, so the bus master can poll with a bare selector byte until it receives an ACK. The block oversamples SCL and SDA with the system clock. It pulls SDA low only through a drive-low output. The stored contents can be read through a combinational side port, which the bench uses for checking.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, SDA is released (`sda_low_o` = 0), `busy_o` = 0, and every stored byte reads 8'hFF.
- R2: The block acknowledges a selector byte only when its bits [7:4] = 4'b1010, bits [3:1] equal `strap_i` and bit [0] = 0, and no programming interval is running. Any other selector gets no ACK, and neither do the bytes that follow it in that transfer. The only time the block pulls SDA low is during an acknowledge slot.
- R3: The two bytes after an accepted selector form the location {high[5:0], low[7:0]}. High bits [7:6] have no effect on it. Both bytes are acknowledged.
- R4: A single acknowledged data byte followed by Stop is stored at the given location.
- R5: Stored data changes, and `busy_o` rises, only on a Stop that closes a write with at least one complete data byte.
- R6: Each further data byte goes to the next location, and only the low six location bits advance. They wrap from 63 to 0, so the page (location bits [13:6]) never changes within a transfer. Every data byte is acknowledged.
- R7: When more than 64 data bytes arrive, the bytes after the wrap replace the bytes buffered earlier at the same in-page positions. Only the last value written to each position is stored.
- R8: A Stop that arrives before any complete data byte stores nothing and does not raise `busy_o`. A Start in the middle of a write drops everything buffered by that write.
- R9: `busy_o` stays high for exactly BUSY_CYCLES clock cycles. During that time selector bytes get no ACK, and writes attempted in that time store nothing. Once `busy_o` falls, a matching selector is acknowledged again.
- R10: `rd_data_o` shows the stored byte at `rd_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND) |
| sda_low_o | output | 1 | High to pull the data line low |
| strap_i | input | 3 | Board-selected selector bits |
| rd_addr_i | input | MEM_AW | Side-port read location |
| rd_data_o | output | 8 | Side-port read data |
| busy_o | output | 1 | Programming interval in progress |

## Verification
Both bus lines pass through a two-stage synchroniser and then an edge register. A bus event therefore takes effect three to four system cycles after the pin changes. The ACK drive appears that long after the SCL fall that ends the eighth bit, and `busy_o` rises one cycle after the Stop is recognised. The bench model holds each bus phase for six cycles and samples the acknowledge level at mid-SCL-high, so every check falls well clear of those latencies. After each Stop it waits for `busy_o` to rise, then counts the clock cycles for which `busy_o` stays high. Stored data is compared through the side port, one time step after the location is set, against a bench-side array updated by the wrap rule.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int ADDR_W = 14;
  localparam logic [3:0] FAMILY_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_DATA, ST_SKIP
  } smt_state_e;

  // selector byte: family code, strap bits, write direction
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == FAMILY_CODE) && (b[3:1] == strap) && !b[0];
  endfunction

  // advance only the in-page bits, wrapping inside the page
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a, input int pw);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((64'(1) << pw) - 64'(1));
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction

  // location of in-page slot `off` on the page of `a`
  function automatic logic [ADDR_W-1:0] join_page(input logic [ADDR_W-1:0] a, input int off,
                                                  input int pw);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((64'(1) << pw) - 64'(1));
    return (a & ~m) | (ADDR_W'(off) & m);
  endfunction
endpackage

// File: rtl/smt_line_sync.sv
module smt_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_sh[SYNC-1];
      sda_q  <= sda_sh[SYNC-1];
    end
  end

  assign scl_s      = scl_sh[SYNC-1];
  assign sda_o      = sda_sh[SYNC-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smt_proto.sv
module smt_proto import smt_pkg::*; #(
  parameter int PAGE_BYTES = 64,
  localparam int PAGE_AW = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  input  logic               busy_i,
  output logic               sda_low_o,
  output logic               ack_phase_o,
  output logic               byte_evt_o,
  output logic               ctrl_evt_o,
  output logic               commit_o,
  output logic               clear_o,
  output logic               wr_en_o,
  output logic [PAGE_AW-1:0] wr_idx_o,
  output logic [7:0]         wr_byte_o,
  output logic [ADDR_W-1:0]  ptr_o,
  output smt_state_e         state_o
);
  localparam int HI_W = ADDR_W - 8;

  smt_state_e        state, nxt;
  logic [7:0]        sh;
  logic [3:0]        cnt;
  logic [HI_W-1:0]   hi;
  logic [ADDR_W-1:0] ptr;
  logic              got, in_ack, sda_low, ack;

  assign byte_evt_o = (state != ST_IDLE) && scl_fall_i && !in_ack && (cnt == 4'd8)
                      && !start_i && !stop_i;
  assign ctrl_evt_o = byte_evt_o && (state == ST_CTRL);
  assign wr_en_o    = byte_evt_o && (state == ST_DATA);
  assign commit_o   = stop_i && (state == ST_DATA) && got;
  assign clear_o    = start_i | stop_i;
  assign wr_idx_o   = ptr[PAGE_AW-1:0];
  assign wr_byte_o  = sh;
  assign ptr_o      = ptr;
  assign state_o    = state;
  assign sda_low_o  = sda_low;
  assign ack_phase_o = in_ack;

  always_comb begin
    nxt = state;
    ack = 1'b0;
    case (state)
      ST_CTRL: if (ctrl_hit(sh, strap_i) && !busy_i) begin nxt = ST_AHI; ack = 1'b1; end
               else nxt = ST_SKIP;
      ST_AHI:  begin nxt = ST_ALO;  ack = 1'b1; end
      ST_ALO:  begin nxt = ST_DATA; ack = 1'b1; end
      ST_DATA: ack = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; sh <= '0; cnt <= '0; hi <= '0; ptr <= '0;
      got <= 1'b0; in_ack <= 1'b0; sda_low <= 1'b0;
    end else if (start_i) begin
      state <= ST_CTRL; cnt <= '0; got <= 1'b0; in_ack <= 1'b0; sda_low <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE; cnt <= '0; got <= 1'b0; in_ack <= 1'b0; sda_low <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise_i && !in_ack && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_i};
        cnt <= cnt + 4'd1;
      end
      if (scl_fall_i) begin
        if (in_ack) begin
          in_ack <= 1'b0; sda_low <= 1'b0; cnt <= '0;
        end else if (cnt == 4'd8) begin
          in_ack  <= 1'b1;
          sda_low <= ack;
          state   <= nxt;
          if (state == ST_AHI) hi <= sh[HI_W-1:0];
          if (state == ST_ALO) ptr <= {hi, sh};
          if (state == ST_DATA) begin
            ptr <= page_step(ptr, PAGE_AW);
            got <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/smt_page_buf.sv
module smt_page_buf #(
  parameter int PAGE_BYTES = 64,
  localparam int PAGE_AW = $clog2(PAGE_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       wr_en_i,
  input  logic [PAGE_AW-1:0]         wr_idx_i,
  input  logic [7:0]                 wr_byte_i,
  output logic [PAGE_BYTES-1:0][7:0] data_o,
  output logic [PAGE_BYTES-1:0]      valid_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] d;
    logic       v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d <= '0;
        v <= 1'b0;
      end else if (clear_i) begin
        v <= 1'b0;
      end else if (wr_en_i && wr_idx_i == PAGE_AW'(g)) begin
        d <= wr_byte_i;
        v <= 1'b1;
      end
    end
    assign data_o[g]  = d;
    assign valid_o[g] = v;
  end
endmodule

// File: rtl/smt_busy_timer.sv
module smt_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 5000,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic busy_o
);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (kick_i)       left <= CW'(BUSY_CYCLES);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy_o = (left != '0);
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target import smt_pkg::*; #(
  parameter int          MEM_AW      = 10,
  parameter int          PAGE_BYTES  = 64,
  parameter int unsigned BUSY_CYCLES = 5000,
  localparam int PAGE_AW   = $clog2(PAGE_BYTES),
  localparam int MEM_DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [2:0]        strap_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  logic ev_rise, ev_fall, ev_start, ev_stop, sda_s;
  logic ev_byte, ev_ctrl_byte, ev_commit, buf_clear, buf_wr, ack_phase;
  logic [PAGE_AW-1:0]         buf_idx;
  logic [7:0]                 buf_byte;
  logic [ADDR_W-1:0]          wr_ptr;
  smt_state_e                 st_now;
  logic [PAGE_BYTES-1:0][7:0] pg_data;
  logic [PAGE_BYTES-1:0]      pg_valid;
  logic [7:0]                 mem [MEM_DEPTH];

  smt_line_sync #(.SYNC(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(ev_rise), .scl_fall_o(ev_fall), .start_o(ev_start), .stop_o(ev_stop),
    .sda_o(sda_s));

  smt_proto #(.PAGE_BYTES(PAGE_BYTES)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise_i(ev_rise), .scl_fall_i(ev_fall),
    .start_i(ev_start), .stop_i(ev_stop), .sda_i(sda_s), .strap_i(strap_i),
    .busy_i(busy_o), .sda_low_o(sda_low_o), .ack_phase_o(ack_phase),
    .byte_evt_o(ev_byte), .ctrl_evt_o(ev_ctrl_byte), .commit_o(ev_commit),
    .clear_o(buf_clear), .wr_en_o(buf_wr), .wr_idx_o(buf_idx), .wr_byte_o(buf_byte),
    .ptr_o(wr_ptr), .state_o(st_now));

  smt_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear_i(buf_clear), .wr_en_i(buf_wr),
    .wr_idx_i(buf_idx), .wr_byte_i(buf_byte), .data_o(pg_data), .valid_o(pg_valid));

  smt_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick_i(ev_commit), .busy_o(busy_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
    end else if (ev_commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pg_valid[i]) mem[MEM_AW'(join_page(wr_ptr, i, PAGE_AW))] <= pg_data[i];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/smt_checker.sv
module smt_checker import smt_pkg::*; #(
  parameter int unsigned BUSY_CYCLES = 5000,
  parameter int          PAGE_AW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              sda_low_o,
  input logic              ack_phase,
  input logic              ev_ctrl_byte,
  input logic              ev_commit,
  input logic              ev_stop,
  input logic [ADDR_W-1:0] wr_ptr,
  input smt_state_e        st_now
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  AST_DRIVE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> ack_phase); // R2
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ctrl_byte && busy_o) |=> !sda_low_o); // R9
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> busy_o); // R5
  AST_BUSY_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(ev_stop)); // R5
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_now == ST_DATA && $past(st_now) == ST_DATA)
      |-> wr_ptr[ADDR_W-1:PAGE_AW] == $past(wr_ptr[ADDR_W-1:PAGE_AW])); // R6
  AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_len == BUSY_CYCLES); // R9
endmodule

bind serial_mem_target smt_checker #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sda_low_o(sda_low_o),
  .ack_phase(ack_phase), .ev_ctrl_byte(ev_ctrl_byte), .ev_commit(ev_commit),
  .ev_stop(ev_stop), .wr_ptr(wr_ptr), .st_now(st_now));

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;
  localparam int MEM_AW = 8;
  localparam int BUSY   = 300;
  localparam int Q      = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic drv_low, busy;
  logic [MEM_AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  wire sda_line = m_sda & ~drv_low;
  logic [7:0] ref_mem [256];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  serial_mem_target #(.MEM_AW(MEM_AW), .PAGE_BYTES(64), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_low_o(drv_low),
    .strap_i(STRAP), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy));

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic write_seq(input int addr, input int n, input int seed, input bit ok);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(SEL_W, a);                              chk(a == ok, "R2 selector ack", a, ok);
    send_byte(8'hC0 | 8'((addr >> 8) & 63), a);       chk(a == ok, "R3 high ack", a, ok);
    send_byte(8'(addr), a);                           chk(a == ok, "R3 low ack", a, ok);
    for (int k = 0; k < n; k++) begin
      d = 8'(seed + k * 37);
      send_byte(d, a);                                chk(a == ok, "R6 data ack", a, ok);
      if (ok) ref_mem[(addr & 8'hC0) | ((addr + k) & 63)] = d;
    end
    bus_stop();
  endtask

  task automatic wait_busy();
    int w = 0, len = 0;
    while (!busy && w < 30) begin @(negedge clk); w++; end
    chk(busy == 1'b1, "R5 busy rises after stop", busy, 1);
    while (busy && len < BUSY + 50) begin @(negedge clk); len++; end
    chk(len == BUSY, "R9 busy length", len, BUSY);
  endtask

  task automatic poll(output bit acked);
    bus_start(); send_byte(SEL_W, acked); bus_stop();
  endtask

  task automatic cmp_mem(input string tag);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); rd_addr = 8'(a); #1;
      chk(rd_data == ref_mem[a], tag, rd_data, ref_mem[a]);
    end
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(drv_low == 1'b0, "R1 sda released", drv_low, 0);
    chk(busy == 1'b0, "R1 busy low", busy, 0);
    cmp_mem("R1 R10 erased contents");

    // R2: selector sweep over strap values and direction
    for (int s = 0; s < 8; s++)
      for (int rw = 0; rw < 2; rw++) begin
        bus_start();
        send_byte({4'b1010, 3'(s), 1'(rw)}, a);
        chk(a == (s == STRAP && rw == 0), "R2 selector sweep", a, (s == STRAP && rw == 0));
        bus_stop(); wq();
      end
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a);
    chk(a == 1'b0, "R2 wrong family code", a, 0);
    send_byte(8'h00, a); chk(a == 1'b0, "R2 following byte ignored", a, 0);
    bus_stop(); repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 no busy without data", busy, 0);

    write_seq(8'h12, 1, 8'h5A, 1'b1); wait_busy(); cmp_mem("R4 byte write");

    write_seq(8'h30, 1, 8'h11, 1'b1);
    poll(a); chk(a == 1'b0, "R9 poll refused while busy", a, 0);
    chk(busy == 1'b1, "R9 busy during poll", busy, 1);
    for (int w = 0; w < BUSY + 50 && busy; w++) @(negedge clk);
    poll(a); chk(a == 1'b1, "R9 poll accepted after busy", a, 1);
    cmp_mem("R9 R10 after poll");

    write_seq(8'h40, 64, 3, 1'b1); wait_busy(); cmp_mem("R6 full page");
    write_seq(8'h8C, 70, 8'h20, 1'b1); wait_busy(); cmp_mem("R7 page overrun wrap");

    // R8: stop in the middle of the first data byte
    bus_start(); send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'hE0, a);
    send_bits(8'hA5, 5); bus_stop(); repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 partial byte no busy", busy, 0);
    cmp_mem("R8 partial byte nothing stored");

    // R8: repeated start after two data bytes discards them
    bus_start(); send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'hD0, a);
    send_byte(8'h01, a); send_byte(8'h02, a);
    bus_start(); send_byte(SEL_W, a); bus_stop(); repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 restart no busy", busy, 0);
    cmp_mem("R8 restart nothing stored");

    // R9: write attempted during programming is refused
    write_seq(8'h20, 1, 8'h77, 1'b1);
    write_seq(8'h21, 2, 8'h99, 1'b0);
    for (int w = 0; w < BUSY + 50 && busy; w++) @(negedge clk);
    chk(busy == 1'b0, "R9 busy ends", busy, 0);
    cmp_mem("R9 refused write not stored");

    summary();
  end
endmodule